// File: doc/BRIEF.md
# Root-Port Interrupt Event Collector

This block gathers the interrupt sources of a PCIe root-port bridge into one level interrupt line. Six decoded event strobes (completion timeout, power-management event received, PME turn-off acknowledge received, correctable error, non-fatal error and fatal error) are latched as pending flags. Four legacy INTx level inputs are tracked live. Software sees one 32-bit pending word and one 32-bit mask word.

Software changes the mask only through two write-only ports. One port unmasks the bits written as one, and the other masks them. A write of zero to either port changes nothing, so drivers need no read-modify-write. Pending event flags are cleared by writing one to them. The interrupt output stays high while any pending bit is unmasked.

Register access uses a plain 32-bit read/write strobe bus with no back-pressure. The bus accepts a write on every cycle that `bus_wr_i` is high. It returns read data in the cycle after `bus_rd_i`. The bus has no ready signal, so the master never waits.

Top module: `pcie_irq_collector`

## Requirements
- R1: After reset the pending word reads 0x00000000, the mask word reads 0x1F558000 (every implemented source masked) and `irq_o` is low.
- R2: A one-cycle strobe on `evt_pulse_i[i]` sets pending bit 15, 24, 25, 26, 27 or 28 for i = 0 to 5 respectively (timeout, PME received, PME-ack, correctable, non-fatal, fatal). The bit is visible after the next clock edge.
- R3: Writing the pending word (offset 0x4C0) clears each event bit written as 1 and leaves each bit written as 0 unchanged.
- R4: If an event strobe and a clearing write hit the same bit in the same cycle, the bit stays set.
- R5: INTx line x (A=0 to D=3) reports at pending bit 16+2x. The bit follows the input level one clock later. A clearing write has no effect on it while the line is asserted.
- R6: Writing the enable port (offset 0x4C8) clears mask bit n wherever data bit n is 1 and the bit is implemented. Zero bits change nothing.
- R7: Writing the disable port (offset 0x4CC) sets mask bit n wherever data bit n is 1 and the bit is implemented. Zero bits change nothing.
- R8: `irq_o` is high exactly when some bit is both pending and unmasked. It stays high for as long as that holds.
- R9: Unimplemented pending and mask bits read 0. Writes to the mask word (0x4C4) are ignored. Reads of the enable port, the disable port or any unmapped offset return 0.
- R10: Read data appears on `bus_rdata_o` after the clock edge that samples `bus_rd_i`, and is held until the next read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| evt_pulse_i | input | 6 | Decoded event strobes, one cycle each |
| intx_i | input | 4 | Legacy INTx A-D levels |
| bus_wr_i | input | 1 | Register write strobe |
| bus_rd_i | input | 1 | Register read strobe |
| bus_addr_i | input | 12 | Byte address |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data, one-cycle latency |
| irq_o | output | 1 | Level interrupt request |

## Verification
The bench builds the block with its default parameters. These are a 12-bit address with the register window at 0x4C0, four INTx lines at stride two from bit 16, and the six fixed event positions. With these values, sparse event bits, interleaved INTx bits and the unimplemented gaps between them all appear in one word. This lets a single pending/mask readback show set-wins collisions, live-level INTx bits that resist clearing, and writes landing on bits that do not exist.

// File: rtl/irq_coll_pkg.sv
package irq_coll_pkg;
  localparam int NUM_EVT = 6;
  // bit position of each event strobe in the pending word
  localparam int EVT_POS [NUM_EVT] = '{15, 24, 25, 26, 27, 28};

  typedef enum logic [2:0] {
    SEL_NONE,
    SEL_PEND,
    SEL_MASK,
    SEL_UNMASK,
    SEL_SETMASK
  } reg_sel_e;

  function automatic logic [31:0] evt_bits();
    logic [31:0] m;
    m = '0;
    for (int i = 0; i < NUM_EVT; i++) m[EVT_POS[i]] = 1'b1;
    return m;
  endfunction

  function automatic logic [31:0] intx_bits(int lines, int lsb, int stride);
    logic [31:0] m;
    m = '0;
    for (int i = 0; i < lines; i++) m[lsb + stride * i] = 1'b1;
    return m;
  endfunction
endpackage

// File: rtl/irq_coll_decode.sv
module irq_coll_decode
  import irq_coll_pkg::*;
#(
  parameter int          ADDR_W    = 12,
  parameter logic [11:0] BASE_ADDR = 12'h4C0
) (
  input  logic              en_i,
  input  logic [ADDR_W-1:0] addr_i,
  output reg_sel_e          sel_o
);
  localparam logic [ADDR_W-1:0] A_PEND    = ADDR_W'(BASE_ADDR);
  localparam logic [ADDR_W-1:0] A_MASK    = ADDR_W'(BASE_ADDR + 12'h4);
  localparam logic [ADDR_W-1:0] A_UNMASK  = ADDR_W'(BASE_ADDR + 12'h8);
  localparam logic [ADDR_W-1:0] A_SETMASK = ADDR_W'(BASE_ADDR + 12'hC);

  always_comb begin
    sel_o = SEL_NONE;
    if (en_i) begin
      unique case (addr_i)
        A_PEND:    sel_o = SEL_PEND;
        A_MASK:    sel_o = SEL_MASK;
        A_UNMASK:  sel_o = SEL_UNMASK;
        A_SETMASK: sel_o = SEL_SETMASK;
        default:   sel_o = SEL_NONE;
      endcase
    end
  end
endmodule

// File: rtl/irq_coll_pending.sv
module irq_coll_pending #(
  parameter int          DATA_W    = 32,
  parameter logic [31:0] EVT_BITS  = 32'h0,
  parameter logic [31:0] INTX_BITS = 32'h0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DATA_W-1:0] evt_vec_i,
  input  logic [DATA_W-1:0] intx_vec_i,
  input  logic              clr_we_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] pend_o
);
  logic [DATA_W-1:0] evt_q;
  logic [DATA_W-1:0] lvl_q;
  logic [DATA_W-1:0] clr_mask;

  assign clr_mask = clr_we_i ? wdata_i : '0;

  // new events override a clear of the same bit
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      evt_q <= '0;
      lvl_q <= '0;
    end else begin
      evt_q <= ((evt_q & ~clr_mask) | evt_vec_i) & EVT_BITS;
      lvl_q <= intx_vec_i & INTX_BITS;
    end
  end

  assign pend_o = evt_q | lvl_q;

  a_r2_event_sets: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_vec_i != '0) |=> ((pend_o & $past(evt_vec_i & EVT_BITS)) == $past(evt_vec_i & EVT_BITS)));

  a_r3_clear_works: assert property (@(posedge clk) disable iff (!rst_n)
    clr_we_i |=> ((pend_o & $past(wdata_i & ~evt_vec_i & EVT_BITS)) == '0));

  a_r5_level_follow: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((pend_o & INTX_BITS) == $past(intx_vec_i & INTX_BITS)));
endmodule

// File: rtl/irq_coll_mask.sv
module irq_coll_mask #(
  parameter int          DATA_W    = 32,
  parameter logic [31:0] IMPL_BITS = 32'h0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              unmask_we_i,
  input  logic              setmask_we_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] mask_o
);
  logic [DATA_W-1:0] mask_q;
  logic [DATA_W-1:0] hit;

  assign hit = wdata_i & IMPL_BITS;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            mask_q <= IMPL_BITS;
    else if (unmask_we_i)  mask_q <= mask_q & ~hit;
    else if (setmask_we_i) mask_q <= mask_q | hit;
  end

  assign mask_o = mask_q;

  a_r6_unmask: assert property (@(posedge clk) disable iff (!rst_n)
    unmask_we_i |=> ((mask_o & $past(hit)) == '0));

  a_r6_unmask_keeps: assert property (@(posedge clk) disable iff (!rst_n)
    unmask_we_i |=> ((mask_o & ~$past(hit)) == ($past(mask_o) & ~$past(hit))));

  a_r7_setmask: assert property (@(posedge clk) disable iff (!rst_n)
    (setmask_we_i && !unmask_we_i) |=> ((mask_o & $past(hit)) == $past(hit)));

  a_r9_mask_impl: assert property (@(posedge clk) disable iff (!rst_n)
    (mask_o & ~IMPL_BITS) == '0);
endmodule

// File: rtl/pcie_irq_collector.sv
module pcie_irq_collector
  import irq_coll_pkg::*;
#(
  parameter int          ADDR_W      = 12,
  parameter logic [11:0] BASE_ADDR   = 12'h4C0,
  parameter int          NUM_INTX    = 4,
  parameter int          INTX_LSB    = 16,
  parameter int          INTX_STRIDE = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NUM_EVT-1:0]  evt_pulse_i,
  input  logic [NUM_INTX-1:0] intx_i,
  input  logic                bus_wr_i,
  input  logic                bus_rd_i,
  input  logic [ADDR_W-1:0]   bus_addr_i,
  input  logic [31:0]         bus_wdata_i,
  output logic [31:0]         bus_rdata_o,
  output logic                irq_o
);
  localparam int          DATA_W    = 32;
  localparam logic [31:0] EVT_M     = evt_bits();
  localparam logic [31:0] INTX_M    = intx_bits(NUM_INTX, INTX_LSB, INTX_STRIDE);
  localparam logic [31:0] IMPL_M    = EVT_M | INTX_M;

  logic [DATA_W-1:0] evt_vec, intx_vec, pend, mask;
  logic [DATA_W-1:0] rdata_q, rd_mux;
  reg_sel_e          wsel, rsel;

  // place strobes and levels at their word positions
  always_comb begin
    evt_vec = '0;
    for (int i = 0; i < NUM_EVT; i++) evt_vec[EVT_POS[i]] = evt_pulse_i[i];
  end

  always_comb begin
    intx_vec = '0;
    for (int i = 0; i < NUM_INTX; i++) intx_vec[INTX_LSB + INTX_STRIDE * i] = intx_i[i];
  end

  irq_coll_decode #(.ADDR_W(ADDR_W), .BASE_ADDR(BASE_ADDR)) u_wdec (
    .en_i(bus_wr_i), .addr_i(bus_addr_i), .sel_o(wsel));

  irq_coll_decode #(.ADDR_W(ADDR_W), .BASE_ADDR(BASE_ADDR)) u_rdec (
    .en_i(bus_rd_i), .addr_i(bus_addr_i), .sel_o(rsel));

  irq_coll_pending #(.DATA_W(DATA_W), .EVT_BITS(EVT_M), .INTX_BITS(INTX_M)) u_pend (
    .clk(clk), .rst_n(rst_n),
    .evt_vec_i(evt_vec), .intx_vec_i(intx_vec),
    .clr_we_i(wsel == SEL_PEND), .wdata_i(bus_wdata_i),
    .pend_o(pend));

  irq_coll_mask #(.DATA_W(DATA_W), .IMPL_BITS(IMPL_M)) u_mask (
    .clk(clk), .rst_n(rst_n),
    .unmask_we_i(wsel == SEL_UNMASK), .setmask_we_i(wsel == SEL_SETMASK),
    .wdata_i(bus_wdata_i), .mask_o(mask));

  always_comb begin
    unique case (rsel)
      SEL_PEND: rd_mux = pend;
      SEL_MASK: rd_mux = mask;
      default:  rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        rdata_q <= '0;
    else if (bus_rd_i) rdata_q <= rd_mux;
  end

  assign bus_rdata_o = rdata_q;
  assign irq_o       = |(pend & ~mask);

  a_r9_pend_impl: assert property (@(posedge clk) disable iff (!rst_n)
    (pend & ~IMPL_M) == '0);

  a_r10_read_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_rd_i |=> $stable(bus_rdata_o));

  a_r9_wo_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd_i && (rsel == SEL_UNMASK || rsel == SEL_SETMASK)) |=> (bus_rdata_o == '0));

  a_r4_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (wsel == SEL_PEND && (bus_wdata_i & evt_vec) != '0) |=> ((pend & $past(evt_vec)) == $past(evt_vec)));
endmodule

// File: tb/pcie_irq_collector_test.sv
module pcie_irq_collector_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [5:0]  evt = '0;
  logic [3:0]  intx = '0;
  logic        wr = 1'b0, rd = 1'b0;
  logic [11:0] addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        irq;

  int checks = 0, fails = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  pcie_irq_collector uut (
    .clk(clk), .rst_n(rst_n), .evt_pulse_i(evt), .intx_i(intx),
    .bus_wr_i(wr), .bus_rd_i(rd), .bus_addr_i(addr), .bus_wdata_i(wdata),
    .bus_rdata_o(rdata), .irq_o(irq));

  localparam logic [11:0] OFS [4] = '{12'h4C0, 12'h4C4, 12'h4C8, 12'h4CC};
  localparam logic [31:0] M_ALL = 32'h1F558000;

  // {evt, intx, wr, reg, wdata, exp_pend, exp_mask, exp_irq}
  localparam int VW = 6 + 4 + 1 + 2 + 32 + 32 + 32 + 1;
  localparam int NV = 16;
  localparam logic [VW-1:0] VEC [NV] = '{
    {6'h01, 4'h0, 1'b0, 2'd0, 32'h0,        32'h00008000, M_ALL,        1'b0},
    {6'h00, 4'h0, 1'b1, 2'd2, 32'h00008000, 32'h00008000, 32'h1F550000, 1'b1},
    {6'h00, 4'h0, 1'b1, 2'd0, 32'h00000000, 32'h00008000, 32'h1F550000, 1'b1},
    {6'h00, 4'h0, 1'b1, 2'd0, 32'h00008000, 32'h00000000, 32'h1F550000, 1'b0},
    {6'h20, 4'h0, 1'b0, 2'd0, 32'h0,        32'h10000000, 32'h1F550000, 1'b0},
    {6'h00, 4'h0, 1'b1, 2'd2, 32'hFFFFFFFF, 32'h10000000, 32'h00000000, 1'b1},
    {6'h00, 4'h0, 1'b1, 2'd3, 32'h10000000, 32'h10000000, 32'h10000000, 1'b0},
    {6'h00, 4'h5, 1'b0, 2'd0, 32'h0,        32'h10110000, 32'h10000000, 1'b1},
    {6'h00, 4'h5, 1'b1, 2'd0, 32'h00110000, 32'h10110000, 32'h10000000, 1'b1},
    {6'h00, 4'h0, 1'b1, 2'd0, 32'h10000000, 32'h00000000, 32'h10000000, 1'b0},
    {6'h3F, 4'h0, 1'b0, 2'd0, 32'h0,        32'h1F008000, 32'h10000000, 1'b1},
    {6'h00, 4'h0, 1'b1, 2'd3, 32'h00000000, 32'h1F008000, 32'h10000000, 1'b1},
    {6'h3F, 4'h0, 1'b1, 2'd0, 32'h1F008000, 32'h1F008000, 32'h10000000, 1'b1},
    {6'h00, 4'h0, 1'b1, 2'd1, 32'hFFFFFFFF, 32'h1F008000, 32'h10000000, 1'b1},
    {6'h00, 4'h0, 1'b1, 2'd0, 32'hFFFFFFFF, 32'h00000000, 32'h10000000, 1'b0},
    {6'h00, 4'h8, 1'b1, 2'd3, 32'hFFFFFFFF, 32'h00400000, M_ALL,        1'b0}
  };

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // read one register; sampled at the negedge after the capturing edge
  task automatic bus_read(input logic [11:0] a, output logic [31:0] d);
    rd = 1'b1; addr = a;
    @(negedge clk);
    rd = 1'b0;
    d = rdata;
  endtask

  initial begin
    logic [31:0] r;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check("R1 irq after reset", {31'b0, irq}, 32'h0);
    bus_read(OFS[0], r); check("R1 pending after reset", r, 32'h0);
    bus_read(OFS[1], r); check("R1 mask after reset", r, M_ALL);

    for (int v = 0; v < NV; v++) begin
      logic [VW-1:0] e;
      e = VEC[v];
      evt   = e[VW-1 -: 6];
      intx  = e[VW-7 -: 4];
      wr    = e[VW-11];
      addr  = OFS[e[VW-12 -: 2]];
      wdata = e[VW-14 -: 32];
      @(negedge clk);
      evt = '0; wr = 1'b0; wdata = '0;
      bus_read(OFS[0], r);
      check($sformatf("R2 R3 R4 R5 pending vec %0d", v), r, e[64:33]);
      bus_read(OFS[1], r);
      check($sformatf("R6 R7 R9 mask vec %0d", v), r, e[32:1]);
      check($sformatf("R8 irq vec %0d", v), {31'b0, irq}, {31'b0, e[0]});
    end

    // R9 write-only ports and unmapped offset read as zero
    intx = '0;
    bus_read(OFS[2], r); check("R9 enable port reads zero", r, 32'h0);
    bus_read(OFS[3], r); check("R9 disable port reads zero", r, 32'h0);
    bus_read(12'h4D0, r); check("R9 unmapped reads zero", r, 32'h0);

    // R10 read latency and hold: data not present before the edge, held after
    evt = 6'h02;
    @(negedge clk);
    evt = '0;
    rd = 1'b1; addr = OFS[0];
    #1 check("R10 old data before edge", rdata, 32'h0);
    @(negedge clk);
    rd = 1'b0;
    check("R10 data after edge", rdata, 32'h01000000);
    @(negedge clk);
    check("R10 data held", rdata, 32'h01000000);

    // R9 write to unmapped offset leaves state
    wr = 1'b1; addr = 12'h4D0; wdata = 32'hFFFFFFFF;
    @(negedge clk);
    wr = 1'b0;
    bus_read(OFS[1], r); check("R9 unmapped write mask", r, M_ALL);
    bus_read(OFS[0], r); check("R9 unmapped write pending", r, 32'h01000000);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    #200000;
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end
endmodule